// File: doc/BRIEF.md
# Indirect IIR Coefficient Access Port

This block is the software-facing store for the coefficients of a cascaded audio IIR filter. Each filter instance keeps five bands of five coefficients. Each coefficient is 30 bits wide. Software reaches the store through a byte-wide register port. It first loads a byte pointer, then moves bytes through a data register. Writes stream forward on their own, because every data write advances the pointer. Reads stay on the same byte, so software reloads the pointer before each byte it fetches.

Every stored coefficient, together with a per-band enable mask, is driven in parallel to the filter datapath. The datapath therefore sees new values as soon as they are written. Two filter instances share one register port. Each instance sits in its own window of 16 register addresses.

Top module: `iir_coef_port`

## Requirements
- R1: After reset, every coefficient, every byte pointer and every band-enable bit is zero, and the read data output is zero.
- R2: A write to a filter's pointer register (window offset 0) keeps only bits 6:0 of the write data. Reading the pointer back returns that 7-bit value with bit 7 clear.
- R3: A write to the data register (window offset 1) stores the byte at the current pointer. The byte address of byte k of coefficient c in band b is (b*5 + c)*4 + k, and byte 0 is the least significant. The parallel bus carries coefficient w = b*5 + c of filter f in bits ((f*25 + w)*30) upward, 30 bits wide.
- R4: After each data-register write the pointer goes up by one, and it wraps from 127 to 0.
- R5: A data-register read returns the byte at the current pointer and leaves the pointer unchanged. The byte and a one-cycle valid pulse appear in the cycle after the read strobe.
- R6: The fourth byte of each coefficient holds only 6 bits. Bits 7:6 of a byte written there are dropped, and they read back as zero.
- R7: Pointer values 100 to 127 lie outside the store. Data writes there change no coefficient but still advance the pointer, and data reads there return zero.
- R8: The band-enable register (window offset 2) takes write-data bits 4:0 as the enables of bands 0 to 4. Upper bits are discarded and read back as zero. Filter f's enables appear on band_en_o bits f*5 to f*5+4.
- R9: Filter f's registers are at address f*16 plus the offset. The two filters keep independent state. Accesses to any other address change nothing and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Register address: filter index above, window offset in bits 3:0 |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Pulses one cycle after a read strobe |
| coef_o | output | 1500 | All coefficients of both filters, 30 bits each |
| band_en_o | output | 10 | Band enables, five per filter |

## Verification
One coefficient stream is loaded with values whose top byte has bits 7:6 set. This shows whether the byte order is least significant first, and whether the reserved bits are dropped both in the parallel bus and on read-back. Repeated reads at one pointer check that reads leave the pointer alone. Pointer values 99, 100 and 127 separate the last valid byte, the out-of-range gap and the wrap back to byte 0. Writes to the second window and to unmapped addresses show whether the filters are independent and whether the decoder rejects stray addresses.

// File: rtl/iir_coef_pkg.sv
package iir_coef_pkg;
  // Register offsets inside one filter window
  localparam int REG_PTR  = 0;
  localparam int REG_DATA = 1;
  localparam int REG_EN   = 2;
  localparam int NUM_REGS = 3;
endpackage

// File: rtl/iir_coef_decode.sv
module iir_coef_decode
  import iir_coef_pkg::*;
#(
  parameter int NUM_FILT = 2,
  parameter int ADDR_W   = 5,
  parameter int STRIDE   = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_i,
  input  logic                               rd_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  output logic [NUM_FILT-1:0][NUM_REGS-1:0]  wr_sel_o,
  output logic [NUM_FILT-1:0][NUM_REGS-1:0]  rd_sel_o
);
  localparam int OFF_W  = $clog2(STRIDE);
  localparam int FILT_W = ADDR_W - OFF_W;

  logic [FILT_W-1:0] filt;
  logic [OFF_W-1:0]  off;

  assign filt = addr_i[ADDR_W-1:OFF_W];
  assign off  = addr_i[OFF_W-1:0];

  always_comb begin
    wr_sel_o = '0;
    rd_sel_o = '0;
    for (int f = 0; f < NUM_FILT; f++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (filt == FILT_W'(f) && off == OFF_W'(r)) begin
          wr_sel_o[f][r] = wr_i;
          rd_sel_o[f][r] = rd_i;
        end
      end
    end
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel_o)); // R9
  AST_ONE_READ_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_sel_o)); // R9
endmodule

// File: rtl/iir_coef_bank.sv
module iir_coef_bank
  import iir_coef_pkg::*;
#(
  parameter int NUM_BANDS = 5,
  parameter int NUM_COEF  = 5,
  parameter int COEF_W    = 30,
  parameter int PTR_W     = 7
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NUM_REGS-1:0]                    wr_sel_i,
  input  logic [NUM_REGS-1:0]                    rd_sel_i,
  input  logic [7:0]                             wdata_i,
  output logic [7:0]                             rd_byte_o,
  output logic [NUM_BANDS*NUM_COEF*COEF_W-1:0]   coef_o,
  output logic [NUM_BANDS-1:0]                   band_en_o
);
  localparam int NUM_WORDS = NUM_BANDS * NUM_COEF;
  localparam int WBYTES    = (COEF_W + 7) / 8;
  localparam int BSEL_W    = $clog2(WBYTES);
  localparam int PAD_W     = WBYTES * 8;
  localparam int LIMIT     = NUM_WORDS * WBYTES;
  localparam int WIDX_W    = PTR_W - BSEL_W;
  localparam int TOP_BITS  = COEF_W - (WBYTES - 1) * 8;

  logic [PTR_W-1:0]     ptr_q;
  logic [NUM_BANDS-1:0] en_q;
  logic [7:0]           rd_byte_q;
  logic [COEF_W-1:0]    word_q [NUM_WORDS];

  logic                 in_range;
  logic [WIDX_W-1:0]    widx;
  logic [BSEL_W-1:0]    bsel;
  logic [PAD_W-1:0]     cur_pad;
  logic [PAD_W-1:0]     new_pad;
  logic [7:0]           cur_byte;

  assign in_range = (ptr_q < PTR_W'(LIMIT));
  assign widx     = ptr_q[PTR_W-1:BSEL_W];
  assign bsel     = ptr_q[BSEL_W-1:0];

  // Selected word, zero-padded to whole bytes; the pad drops reserved bits
  always_comb begin
    cur_pad = '0;
    if (in_range) cur_pad = PAD_W'(word_q[widx]);
    cur_byte = cur_pad[bsel*8 +: 8];
    new_pad  = cur_pad;
    new_pad[bsel*8 +: 8] = wdata_i;
  end

  // Coefficient words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) word_q[i] <= '0;
    end else if (wr_sel_i[REG_DATA] && in_range) begin
      word_q[widx] <= new_pad[COEF_W-1:0];
    end
  end

  // Pointer, enables and read return
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      en_q      <= '0;
      rd_byte_q <= '0;
    end else begin
      if (wr_sel_i[REG_PTR])       ptr_q <= wdata_i[PTR_W-1:0];
      else if (wr_sel_i[REG_DATA]) ptr_q <= ptr_q + 1'b1;
      if (wr_sel_i[REG_EN])        en_q  <= wdata_i[NUM_BANDS-1:0];
      if (rd_sel_i[REG_DATA])      rd_byte_q <= cur_byte;
      else if (rd_sel_i[REG_PTR])  rd_byte_q <= 8'(ptr_q);
      else if (rd_sel_i[REG_EN])   rd_byte_q <= 8'(en_q);
      else                         rd_byte_q <= '0;
    end
  end

  genvar gw;
  generate
    for (gw = 0; gw < NUM_WORDS; gw++) begin : g_out
      assign coef_o[gw*COEF_W +: COEF_W] = word_q[gw];
    end
  endgenerate

  assign band_en_o = en_q;
  assign rd_byte_o = rd_byte_q;

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (wr_sel_i[REG_DATA] && !wr_sel_i[REG_PTR]) |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1)); // R4
  AST_PTR_STILL_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_i[REG_DATA] && wr_sel_i == '0) |=> $stable(ptr_q)); // R5
  AST_GAP_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_i[REG_DATA] && !in_range) |=> rd_byte_q == 8'd0); // R7
  AST_GAP_WRITE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_sel_i[REG_DATA] && !in_range) |=> $stable(coef_o)); // R7
  AST_TOP_BYTE_MASK: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_i[REG_DATA] && bsel == BSEL_W'(WBYTES - 1)) |=> (rd_byte_q >> TOP_BITS) == 8'd0); // R6
endmodule

// File: rtl/iir_coef_port.sv
module iir_coef_port
  import iir_coef_pkg::*;
#(
  parameter int NUM_FILT  = 2,
  parameter int NUM_BANDS = 5,
  parameter int NUM_COEF  = 5,
  parameter int COEF_W    = 30,
  parameter int PTR_W     = 7,
  parameter int STRIDE    = 16,
  parameter int ADDR_W    = 5
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          reg_wr_i,
  input  logic                                          reg_rd_i,
  input  logic [ADDR_W-1:0]                             reg_addr_i,
  input  logic [7:0]                                    reg_wdata_i,
  output logic [7:0]                                    reg_rdata_o,
  output logic                                          reg_rvalid_o,
  output logic [NUM_FILT*NUM_BANDS*NUM_COEF*COEF_W-1:0] coef_o,
  output logic [NUM_FILT*NUM_BANDS-1:0]                 band_en_o
);
  localparam int BANK_W = NUM_BANDS * NUM_COEF * COEF_W;

  logic [NUM_FILT-1:0][NUM_REGS-1:0] wr_sel;
  logic [NUM_FILT-1:0][NUM_REGS-1:0] rd_sel;
  logic [NUM_FILT-1:0][7:0]          bank_byte;
  logic                              rvalid_q;

  iir_coef_decode #(
    .NUM_FILT (NUM_FILT),
    .ADDR_W   (ADDR_W),
    .STRIDE   (STRIDE)
  ) u_decode (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel)
  );

  genvar gf;
  generate
    for (gf = 0; gf < NUM_FILT; gf++) begin : g_bank
      iir_coef_bank #(
        .NUM_BANDS (NUM_BANDS),
        .NUM_COEF  (NUM_COEF),
        .COEF_W    (COEF_W),
        .PTR_W     (PTR_W)
      ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_sel_i  (wr_sel[gf]),
        .rd_sel_i  (rd_sel[gf]),
        .wdata_i   (reg_wdata_i),
        .rd_byte_o (bank_byte[gf]),
        .coef_o    (coef_o[gf*BANK_W +: BANK_W]),
        .band_en_o (band_en_o[gf*NUM_BANDS +: NUM_BANDS])
      );
    end
  endgenerate

  // Banks return zero unless read, so an OR merges them
  always_comb begin
    reg_rdata_o = '0;
    for (int f = 0; f < NUM_FILT; f++) reg_rdata_o = reg_rdata_o | bank_byte[f];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid_q <= 1'b0;
    else     rvalid_q <= reg_rd_i;
  end
  assign reg_rvalid_o = rvalid_q;

  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    reg_rd_i |=> reg_rvalid_o); // R5
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_i |=> !reg_rvalid_o); // R5
endmodule

// File: tb/iir_coef_port_test.sv
module iir_coef_port_test;
  localparam int NF = 2, NW = 25, CW = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [NF*NW*CW-1:0] coef;
  logic [NF*5-1:0]     ben;

  int checks = 0, fails = 0;
  logic [CW-1:0] exp_w [NF][NW];

  always #4 clk = ~clk;

  iir_coef_port uut (
    .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .coef_o(coef), .band_en_o(ben)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata; v = rvalid;
  endtask

  task automatic check_coefs(input string req);
    int bad = 0;
    longint act = 0, expv = 0;
    for (int f = 0; f < NF; f++)
      for (int w = 0; w < NW; w++)
        if (coef[(f*NW+w)*CW +: CW] !== exp_w[f][w]) begin
          if (bad == 0) begin act = coef[(f*NW+w)*CW +: CW]; expv = exp_w[f][w]; end
          bad++;
        end
    check(bad == 0, req, act, expv);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic v;
    for (int f = 0; f < NF; f++) for (int w = 0; w < NW; w++) exp_w[f][w] = '0;
    check_coefs("R1 coefficients clear");
    check(ben == '0, "R1 enables clear", ben, 0);
    check(rdata == 8'd0, "R1 read data clear", rdata, 0);
    rd_reg(5'd0, d, v);  check(d == 8'd0, "R1 pointer f0 clear", d, 0);
    rd_reg(5'd16, d, v); check(d == 8'd0, "R1 pointer f1 clear", d, 0);
  endtask

  task automatic t_ptr_mask;
    logic [7:0] d; logic v;
    wr_reg(5'd0, 8'hFF);
    rd_reg(5'd0, d, v); check(d == 8'h7F, "R2 pointer mask", d, 8'h7F);
    wr_reg(5'd0, 8'hA5);
    rd_reg(5'd0, d, v); check(d == 8'h25, "R2 pointer mask", d, 8'h25);
  endtask

  task automatic t_stream;
    logic [7:0] d; logic v;
    logic [31:0] val;
    wr_reg(5'd0, 8'd40);  // band 2, coefficient 0
    for (int c = 0; c < 5; c++) begin
      val = 32'hC1234567 + 32'h11111111 * c;
      for (int k = 0; k < 4; k++) wr_reg(5'd1, val[k*8 +: 8]);
      exp_w[0][10+c] = val[29:0];
    end
    check_coefs("R3 R6 stream into band 2");
    rd_reg(5'd0, d, v); check(d == 8'd60, "R4 pointer after 20 writes", d, 60);
  endtask

  task automatic t_readback;
    logic [7:0] d, e; logic v;
    wr_reg(5'd0, 8'd51);  // band 2, coefficient 2, top byte
    e = 8'(exp_w[0][12][29:24]);
    rd_reg(5'd1, d, v);
    check(d == e, "R6 top byte reads masked", d, e);
    check(v == 1'b1, "R5 valid pulse", v, 1);
    @(negedge clk); check(rvalid == 1'b0, "R5 valid only one cycle", rvalid, 0);
    rd_reg(5'd1, d, v); check(d == e, "R5 repeated read same byte", d, e);
    rd_reg(5'd0, d, v); check(d == 8'd51, "R5 pointer unchanged by reads", d, 51);
    wr_reg(5'd0, 8'd48);
    e = exp_w[0][12][7:0];
    rd_reg(5'd1, d, v); check(d == e, "R3 low byte first", d, e);
  endtask

  task automatic t_gap_wrap;
    logic [7:0] d; logic v;
    wr_reg(5'd0, 8'd99);
    wr_reg(5'd1, 8'hFF);
    exp_w[0][24][29:24] = 6'h3F;
    wr_reg(5'd1, 8'hAA);  // pointer 100: ignored
    check_coefs("R7 gap write ignored");
    rd_reg(5'd0, d, v); check(d == 8'd101, "R7 pointer advances in gap", d, 101);
    wr_reg(5'd0, 8'd100);
    rd_reg(5'd1, d, v); check(d == 8'd0, "R7 gap reads zero", d, 0);
    wr_reg(5'd0, 8'd127);
    wr_reg(5'd1, 8'h55);
    rd_reg(5'd0, d, v); check(d == 8'd0, "R4 wrap 127 to 0", d, 0);
    wr_reg(5'd1, 8'h12);
    exp_w[0][0][7:0] = 8'h12;
    check_coefs("R4 write after wrap lands at byte 0");
  endtask

  task automatic t_enables;
    logic [7:0] d; logic v;
    wr_reg(5'd2, 8'hEA);
    rd_reg(5'd2, d, v); check(d == 8'h0A, "R8 enable upper bits dropped", d, 8'h0A);
    wr_reg(5'd18, 8'hFF);
    rd_reg(5'd18, d, v); check(d == 8'h1F, "R8 filter 1 enables", d, 8'h1F);
    check(ben == 10'b11111_01010, "R8 enable outputs", ben, 10'b11111_01010);
  endtask

  task automatic t_map;
    logic [7:0] d; logic v;
    wr_reg(5'd16, 8'd0);
    wr_reg(5'd17, 8'h78); wr_reg(5'd17, 8'h56);
    wr_reg(5'd17, 8'h34); wr_reg(5'd17, 8'hF2);
    exp_w[1][0] = 30'h32345678;
    check_coefs("R9 filter 1 independent store");
    rd_reg(5'd16, d, v); check(d == 8'd4, "R9 filter 1 pointer", d, 4);
    rd_reg(5'd0, d, v);  check(d == 8'd1, "R9 filter 0 pointer untouched", d, 1);
    wr_reg(5'd3, 8'h77);
    wr_reg(5'd21, 8'h33);
    check_coefs("R9 unmapped write no effect");
    check(ben == 10'b11111_01010, "R9 unmapped write keeps enables", ben, 10'b11111_01010);
    rd_reg(5'd3, d, v); check(d == 8'd0, "R9 unmapped read zero", d, 0);
    rd_reg(5'd0, d, v); check(d == 8'd1, "R9 pointer kept after stray write", d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ptr_mask();
    t_stream();
    t_readback();
    t_gap_wrap();
    t_enables();
    t_map();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule